// File: doc/BRIEF.md
# Multiplexed Host Register-Bus Slave

This block sits on an 8-bit multiplexed parallel bus that a host drives from general-purpose pins. Every access takes two bus cycles. In the first cycle the host asserts the address/data select line and writes a byte into an 8-bit register pointer. In the second cycle the select line is deasserted, and the host reads or writes the register that the pointer names. The control strobes are asynchronous to the block clock. Each one passes through a two-flop synchroniser, and an access is accepted on the synchronised falling edge of the write or read strobe while chip select is low.

The sixteen-entry register space holds four kinds of entry. Local configuration bytes are stored in the block and presented to neighbouring logic on a flat output. Two data windows, one for slot data and one for filter data, are forwarded to other blocks through a request/acknowledge port, and the bus ready handshake is withheld until that port acknowledges. A fixed revision byte is read-only. The remaining entries are unmapped. An interrupt event from the rest of the chip sets a pending flag. The active-low interrupt pin follows that flag once the enable bit is set, and a read of the interrupt-control register acknowledges it.

Top module: `hbus_regslave`

## Requirements
- R1: After reset `bus_rdy_n` is 0, `irq_n` is 1, `ext_req` is 0, every byte of `cfg_q` is 0x00 and the pointer is 0x00.
- R2: A write strobe with `bus_sel` high loads the byte on `bus_d_in` into the 8-bit pointer. Strobe falling edges seen while `bus_cs_n` is high are ignored, so the pointer and all registers are left as they were.
- R3: Entries 0x01, 0x04, 0x05, 0x07, 0x08, 0x09, 0x0C and 0x0D, and bits 7:1 of entry 0x00, are local. A data-phase write stores the byte, which then appears on `cfg_q[8*i +: 8]` for entry i. A data-phase read returns the stored value.
- R4: Entry 0x0F reads as the `REVISION` parameter, default 0x3C. Writes to it change nothing.
- R5: Entries 0x02, 0x03, 0x0B and 0x0E, and any pointer value of 0x10 or above, read as 0x00. Writes to them change nothing and raise no `ext_req`.
- R6: A data-phase access to entry 0x06 or 0x0A raises `ext_req` with `ext_addr` equal to the entry, `ext_we` set to 1 for a write and 0 for a read, and `ext_wdata` carrying the written byte. These outputs hold until `ext_ack`. `bus_rdy_n` stays 1 for the whole wait, and a read returns the `ext_rdata` value present with `ext_ack`.
- R7: A one-cycle `irq_evt` pulse sets the pending flag even when interrupts are disabled. `irq_n` is 0 exactly while the flag is pending and bit 6 of entry 0x00 is 1, so writing 0x44 to entry 0x00 enables the interrupt.
- R8: A data-phase read of entry 0x00 returns bits 7:1 of the stored byte with the pending flag in bit 0, and then clears the flag. An `irq_evt` that lands in the same cycle as that read keeps the flag set.
- R9: The read byte is presented on `bus_d_out`. `bus_d_oe` is 1 exactly while both `bus_cs_n` and `bus_rd_n` are low.
- R10: A read strobe with `bus_sel` high returns the current pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_sel | input | 1 | Address/data select, 1 = pointer phase |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_d_in | input | 8 | Byte driven by the host |
| bus_d_out | output | 8 | Byte returned to the host |
| bus_d_oe | output | 1 | Output enable for the bus data pins |
| bus_rdy_n | output | 1 | Ready handshake, active low |
| irq_n | output | 1 | Interrupt to the host, active low |
| irq_evt | input | 1 | Interrupt event pulse from other blocks |
| ext_req | output | 1 | Forwarded access pending |
| ext_we | output | 1 | Forwarded access is a write |
| ext_addr | output | 4 | Entry number of the forwarded access |
| ext_wdata | output | 8 | Write byte of the forwarded access |
| ext_rdata | input | 8 | Read byte returned with the acknowledge |
| ext_ack | input | 1 | Forwarded access completed |
| cfg_q | output | 128 | All sixteen entries as stored, entry i at bits 8*i+7:8*i |

## Verification
The hardest case to bring about is an interrupt event that arrives in the very cycle the acknowledging read of entry 0x00 takes effect. That read clears the flag, and the event must win. The bench reaches it by counting the synchroniser stages from the strobe edge it drives itself and pulsing `irq_evt` in the cycle the read is acted on. It then expects the line to stay asserted until a second read. The forwarded-window wait is also held open for several cycles by the bench's responder, so the withheld ready can be checked while the wait is in progress.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int NREG = 16;
  localparam int DW   = 8;

  localparam logic [7:0] RA_IRQ   = 8'h00;
  localparam logic [7:0] RA_SDATA = 8'h06;
  localparam logic [7:0] RA_FDATA = 8'h0A;
  localparam logic [7:0] RA_REV   = 8'h0F;
  localparam int         IRQ_EN_BIT = 6;

  // entries stored inside the register file
  function automatic logic reg_is_local(input logic [7:0] a);
    case (a)
      8'h00, 8'h01, 8'h04, 8'h05, 8'h07,
      8'h08, 8'h09, 8'h0C, 8'h0D: return 1'b1;
      default:                    return 1'b0;
    endcase
  endfunction

  // entries forwarded to neighbouring blocks
  function automatic logic reg_is_remote(input logic [7:0] a);
    return (a == RA_SDATA) || (a == RA_FDATA);
  endfunction

  // writable bits per entry; bit 0 of the interrupt entry is the pending flag
  function automatic logic [DW-1:0] reg_wmask(input logic [7:0] a);
    return (a == RA_IRQ) ? 8'hFE : 8'hFF;
  endfunction

  // value returned for a local data-phase read
  function automatic logic [DW-1:0] read_value(input logic [7:0] a,
                                               input logic [DW-1:0] file_byte,
                                               input logic pend,
                                               input logic [DW-1:0] rev);
    if (a == RA_REV) return rev;
    if (a == RA_IRQ) return {file_byte[DW-1:1], pend};
    return file_byte;
  endfunction
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int         W   = 4,
  parameter logic [W-1:0] RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST;
      q      <= RST;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile
  import hbus_pkg::*;
#(
  parameter int N = NREG,
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [7:0]   idx,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic [N*W-1:0] q_flat
);
  localparam int IW = $clog2(N);

  logic [W-1:0] regs [N];
  logic         in_range;

  assign in_range = (idx < 8'(N));

  for (genvar i = 0; i < N; i++) begin : g_reg
    if (reg_is_local(8'(i))) begin : g_store
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          r <= '0;
        else if (wr_en && in_range && (idx[IW-1:0] == IW'(i)))
          r <= wr_data & reg_wmask(8'(i));
      end
      assign regs[i] = r;
    end else begin : g_none
      assign regs[i] = '0;
    end
    assign q_flat[i*W +: W] = regs[i];
  end

  assign rd_data = in_range ? regs[idx[IW-1:0]] : '0;
endmodule

// File: rtl/hbus_regslave.sv
module hbus_regslave
  import hbus_pkg::*;
#(
  parameter logic [7:0] REVISION = 8'h3C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_cs_n,
  input  logic               bus_sel,
  input  logic               bus_wr_n,
  input  logic               bus_rd_n,
  input  logic [7:0]         bus_d_in,
  output logic [7:0]         bus_d_out,
  output logic               bus_d_oe,
  output logic               bus_rdy_n,
  output logic               irq_n,
  input  logic               irq_evt,
  output logic               ext_req,
  output logic               ext_we,
  output logic [3:0]         ext_addr,
  output logic [7:0]         ext_wdata,
  input  logic [7:0]         ext_rdata,
  input  logic               ext_ack,
  output logic [NREG*DW-1:0] cfg_q
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  // synchronised controls: {cs, sel, wr, rd}
  logic [3:0] s_ctl;
  logic s_cs, s_sel, s_wr, s_rd;
  hbus_sync #(.W(4), .RST(4'b1011)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({bus_cs_n, bus_sel, bus_wr_n, bus_rd_n}),
    .q   (s_ctl)
  );
  assign {s_cs, s_sel, s_wr, s_rd} = s_ctl;

  st_e         st;
  logic        prev_wr, prev_rd;
  logic [7:0]  ptr_q;
  logic        pend_q;
  logic [7:0]  rd_q;
  logic        rdy_q;
  logic        we_q;
  logic [7:0]  wdata_q;

  // named internal events
  logic wr_evt, rd_evt, ptr_wr, data_wr, data_rd, remote_hit, file_we;
  logic [DW-1:0] file_rd, local_rd;

  assign wr_evt     = prev_wr & ~s_wr & ~s_cs & (st == ST_IDLE);
  assign rd_evt     = prev_rd & ~s_rd & ~s_cs & (st == ST_IDLE) & ~wr_evt;
  assign ptr_wr     = wr_evt & s_sel;
  assign data_wr    = wr_evt & ~s_sel;
  assign data_rd    = rd_evt & ~s_sel;
  assign remote_hit = reg_is_remote(ptr_q);
  assign file_we    = data_wr & ~remote_hit;

  hbus_regfile #(.N(NREG), .W(DW)) u_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (file_we),
    .idx     (ptr_q),
    .wr_data (bus_d_in),
    .rd_data (file_rd),
    .q_flat  (cfg_q)
  );

  assign local_rd = read_value(ptr_q, file_rd, pend_q, REVISION);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      prev_wr <= 1'b1;
      prev_rd <= 1'b1;
      ptr_q   <= '0;
      pend_q  <= 1'b0;
      rd_q    <= '0;
      rdy_q   <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      prev_wr <= s_wr;
      prev_rd <= s_rd;
      if (ptr_wr) ptr_q <= bus_d_in;
      if (irq_evt)
        pend_q <= 1'b1;
      else if (data_rd && (ptr_q == RA_IRQ))
        pend_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if ((data_wr || data_rd) && remote_hit) begin
            st      <= ST_WAIT;
            rdy_q   <= 1'b1;
            we_q    <= data_wr;
            wdata_q <= data_wr ? bus_d_in : 8'h00;
          end else if (data_rd) begin
            rd_q <= local_rd;
          end else if (rd_evt) begin
            rd_q <= ptr_q;
          end
        end
        ST_WAIT: begin
          if (ext_ack) begin
            st    <= ST_IDLE;
            rdy_q <= 1'b0;
            if (!we_q) rd_q <= ext_rdata;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign bus_d_out = rd_q;
  assign bus_d_oe  = ~bus_cs_n & ~bus_rd_n;
  assign bus_rdy_n = rdy_q;
  assign irq_n     = ~(pend_q & cfg_q[IRQ_EN_BIT]);
  assign ext_req   = (st == ST_WAIT);
  assign ext_we    = we_q;
  assign ext_addr  = ptr_q[3:0];
  assign ext_wdata = wdata_q;
endmodule

// File: rtl/hbus_regslave_chk.sv
module hbus_regslave_chk
  import hbus_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               irq_n,
  input logic               irq_evt,
  input logic [NREG*DW-1:0] cfg_q,
  input logic               ext_req,
  input logic               ext_ack,
  input logic               ext_we,
  input logic [3:0]         ext_addr,
  input logic [7:0]         ext_wdata,
  input logic               bus_rdy_n,
  input logic               wr_evt,
  input logic               data_rd,
  input logic [7:0]         ptr_q
);
  // R7: the line only asserts with the enable bit set
  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> cfg_q[IRQ_EN_BIT]);

  // R8: acknowledging read with no new event releases the line
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && ptr_q == RA_IRQ && !irq_evt) |=> irq_n);

  // R6: forwarded request holds its fields until acknowledged
  assert_req_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr) && $stable(ext_we) && $stable(ext_wdata)));

  // R6: ready withheld while a forwarded access is open
  assert_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> bus_rdy_n);

  // R3: configuration bytes move only after an accepted write strobe
  assert_cfg_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(wr_evt));
endmodule

bind hbus_regslave hbus_regslave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_n     (irq_n),
  .irq_evt   (irq_evt),
  .cfg_q     (cfg_q),
  .ext_req   (ext_req),
  .ext_ack   (ext_ack),
  .ext_we    (ext_we),
  .ext_addr  (ext_addr),
  .ext_wdata (ext_wdata),
  .bus_rdy_n (bus_rdy_n),
  .wr_evt    (wr_evt),
  .data_rd   (data_rd),
  .ptr_q     (ptr_q)
);

// File: tb/tb_hbus_regslave.sv
module tb_hbus_regslave;
  localparam logic [7:0] REV = 8'h3C;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_cs_n = 1'b1, bus_sel = 1'b0, bus_wr_n = 1'b1, bus_rd_n = 1'b1;
  logic [7:0]   bus_d_in = 8'h00;
  logic [7:0]   bus_d_out;
  logic         bus_d_oe, bus_rdy_n, irq_n;
  logic         irq_evt = 1'b0;
  logic         ext_req, ext_we;
  logic [3:0]   ext_addr;
  logic [7:0]   ext_wdata;
  logic [7:0]   ext_rdata = 8'h00;
  logic         ext_ack = 1'b0;
  logic [127:0] cfg_q;

  always #5 clk = ~clk;

  hbus_regslave #(.REVISION(REV)) dut (.*);

  int errors = 0, checks = 0;
  bit busy = 1'b1;

  // behavioural reference state
  byte unsigned mdl [16];
  bit           mpend = 1'b0;
  byte unsigned mptr = 0;
  byte unsigned ext_val = 0;
  int           n_req = 0;
  bit           last_we;
  logic [3:0]   last_addr;
  logic [7:0]   last_wdata;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_store(input byte unsigned a);
    return a inside {8'h00, 8'h01, 8'h04, 8'h05, 8'h07, 8'h08, 8'h09, 8'h0C, 8'h0D};
  endfunction

  function automatic logic [127:0] exp_cfg();
    logic [127:0] v = '0;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  function automatic byte unsigned exp_read(input byte unsigned a);
    if (a == 8'h00) return {mdl[0][7:1], mpend};
    if (a == 8'h0F) return REV;
    if (a == 8'h06 || a == 8'h0A) return ext_val;
    if (is_store(a)) return mdl[a];
    return 8'h00;
  endfunction

  // compare the model on every clock while the bus is quiet
  always @(negedge clk) begin
    if (rst_n && !busy) begin
      chk("R3 cfg_q vs model", cfg_q, exp_cfg());
      chk("R7 irq_n vs model", irq_n, !(mpend && mdl[0][6]));
    end
  end

  // responder for forwarded accesses
  initial begin
    forever begin
      @(negedge clk);
      if (ext_req) begin
        n_req++;
        last_we = ext_we; last_addr = ext_addr; last_wdata = ext_wdata;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk("R6 ready withheld during wait", bus_rdy_n, 1'b1);
        end
        ext_rdata = ext_val;
        ext_ack = 1'b1;
        @(negedge clk);
        ext_ack = 1'b0;
      end
    end
  end

  task automatic bus_cycle(input bit sel, input bit is_wr, input byte unsigned d,
                           input bit evt_pulse, output byte unsigned q);
    busy = 1'b1;
    @(negedge clk); bus_cs_n = 1'b0; bus_sel = sel; bus_d_in = d;
    @(negedge clk); if (is_wr) bus_wr_n = 1'b0; else bus_rd_n = 1'b0;
    @(negedge clk);
    @(negedge clk); if (evt_pulse) irq_evt = 1'b1;
    @(negedge clk); irq_evt = 1'b0;
    repeat (2) @(negedge clk);
    while (bus_rdy_n) @(negedge clk);
    q = bus_d_out;
    if (!is_wr) chk("R9 oe during read", bus_d_oe, 1'b1);
    @(negedge clk); bus_wr_n = 1'b1; bus_rd_n = 1'b1;
    @(negedge clk); bus_cs_n = 1'b1;
    if (!is_wr) chk("R9 oe released", bus_d_oe, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_ptr(input byte unsigned a);
    byte unsigned q;
    bus_cycle(1'b1, 1'b1, a, 1'b0, q);
    mptr = a; busy = 1'b0;
  endtask

  task automatic wr_reg(input byte unsigned d);
    byte unsigned q;
    bus_cycle(1'b0, 1'b1, d, 1'b0, q);
    if (is_store(mptr)) mdl[mptr] = (mptr == 0) ? (d & 8'hFE) : d;
    busy = 1'b0;
  endtask

  task automatic rd_reg(input string req, input bit coinc);
    byte unsigned q, e;
    e = exp_read(mptr);
    bus_cycle(1'b0, 1'b0, 8'h00, coinc, q);
    if (mptr == 0) mpend = coinc;
    else if (coinc) mpend = 1'b1;
    chk(req, q, e);
    busy = 1'b0;
  endtask

  task automatic irq_pulse();
    busy = 1'b1;
    @(negedge clk); irq_evt = 1'b1;
    @(negedge clk); irq_evt = 1'b0;
    mpend = 1'b1;
    @(negedge clk);
    busy = 1'b0;
  endtask

  initial begin
    byte unsigned q;
    int req0;
    for (int i = 0; i < 16; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdy_n", bus_rdy_n, 1'b0);
    chk("R1 irq_n", irq_n, 1'b1);
    chk("R1 ext_req", ext_req, 1'b0);
    chk("R1 cfg_q", cfg_q, '0);
    busy = 1'b0;
    bus_cycle(1'b1, 1'b0, 8'h00, 1'b0, q);
    chk("R1 pointer after reset", q, 8'h00);
    busy = 1'b0;

    // R2 / R10 pointer load and readback
    set_ptr(8'h01);
    bus_cycle(1'b1, 1'b0, 8'h00, 1'b0, q);
    chk("R10 pointer readback", q, 8'h01);
    busy = 1'b0;

    // R3 local registers
    wr_reg(8'h5A);
    rd_reg("R3 read 0x01", 1'b0);
    set_ptr(8'h0D); wr_reg(8'hC3); rd_reg("R3 read 0x0D", 1'b0);
    set_ptr(8'h04); wr_reg(8'h81); rd_reg("R3 read 0x04", 1'b0);
    set_ptr(8'h00); wr_reg(8'hBF); rd_reg("R3 read 0x00 bit0 masked", 1'b0);
    wr_reg(8'h00);

    // R4 revision
    set_ptr(8'h0F); rd_reg("R4 revision", 1'b0);
    wr_reg(8'h11); rd_reg("R4 revision after write", 1'b0);

    // R5 unmapped
    req0 = n_req;
    set_ptr(8'h0B); wr_reg(8'h77); rd_reg("R5 read 0x0B", 1'b0);
    set_ptr(8'h16); wr_reg(8'h99); rd_reg("R5 read 0x16", 1'b0);
    chk("R5 no forwarded request", n_req, req0);

    // R2 strobes with chip select high are ignored
    set_ptr(8'h01);
    busy = 1'b1;
    @(negedge clk); bus_sel = 1'b1; bus_d_in = 8'h0D;
    @(negedge clk); bus_wr_n = 1'b0;
    repeat (4) @(negedge clk); bus_wr_n = 1'b1;
    @(negedge clk); bus_rd_n = 1'b0;
    repeat (4) @(negedge clk); bus_rd_n = 1'b1;
    repeat (3) @(negedge clk);
    busy = 1'b0;
    rd_reg("R2 pointer kept with cs high", 1'b0);

    // R6 forwarded windows
    set_ptr(8'h06);
    req0 = n_req;
    wr_reg(8'hA7);
    chk("R6 write request count", n_req, req0 + 1);
    chk("R6 write we", last_we, 1'b1);
    chk("R6 write addr", last_addr, 4'h6);
    chk("R6 write data", last_wdata, 8'hA7);
    set_ptr(8'h0A);
    ext_val = 8'h9E;
    rd_reg("R6 forwarded read data", 1'b0);
    chk("R6 read we", last_we, 1'b0);
    chk("R6 read addr", last_addr, 4'hA);

    // R7 interrupt enable and pending
    irq_pulse();
    chk("R7 disabled line idle", irq_n, 1'b1);
    set_ptr(8'h00);
    wr_reg(8'h44);
    chk("R7 enabled line asserted", irq_n, 1'b0);

    // R8 acknowledge by reading
    rd_reg("R8 read shows pending", 1'b0);
    chk("R8 line released", irq_n, 1'b1);
    irq_pulse();
    chk("R7 line asserted again", irq_n, 1'b0);
    rd_reg("R8 read with coincident event", 1'b1);
    chk("R8 coincident event keeps line", irq_n, 1'b0);
    rd_reg("R8 second read", 1'b0);
    chk("R8 line released after second read", irq_n, 1'b1);

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule